// File: doc/BRIEF.md
# Packed SIMD Lane ALU

This block is a 64-bit packed arithmetic unit for a media datapath. The word is treated either as eight signed byte lanes or as four signed halfword lanes. The format comes from the low bits of a 5-bit select field. The same field also says where the second operand comes from: one element of the second register copied into every lane, the second register lane by lane, or the 5-bit register specifier used as a small constant.

Each accepted request gives a registered result one cycle later, together with a one-cycle output strobe. The operations are saturating add and multiply, wrapping subtract, signed min and max, bitwise logic, and lane shifts. Compares write a set of held per-lane condition bits, and the pick operations then use those bits to merge the two operands lane by lane. A request whose select field names a 32-bit or 64-bit lane format is refused: it raises an illegal flag and leaves all held state as it was.

Lane i sits at bits [8i+7:8i] in byte format and at bits [16i+15:16i] in halfword format.

Top module: `simd_lane_alu`

## Requirements
- R1: The format is decoded from `sel` as follows. `sel[0]=0` selects eight byte lanes. `sel[1:0]=01` selects four halfword lanes. `sel[1:0]=11` is illegal: `illegal` goes to 1 along with `out_valid`, and `result` and `cc` keep their values. A legal request gives `illegal=0`.
- R2: With `sel[4]=0`, the second operand is one lane of `vt` copied into every lane. Its index is `sel[3:1]` in byte format and `sel[3:2]` in halfword format.
- R3: With `sel[4:3]=10`, the second operand is `vt` lane by lane. With `sel[4:3]=11`, it is `spec` zero-extended to the lane width, in every lane.
- R4: Add (opcode 0) and multiply (opcode 2) saturate to the signed lane range. Bytes clamp to 0x7F/0x80 and halfwords to 0x7FFF/0x8000.
- R5: Subtract (opcode 1) returns the first operand minus the second, truncated to the lane width.
- R6: AND (5), OR (6), NOR (7) and XOR (8) are bitwise on the whole lane.
- R7: Min (3) and max (4) choose lanes by signed comparison.
- R8: Shift left (9), logical right (10) and arithmetic right (11) mask the count to 3 bits for bytes and to 4 bits for halfwords. The logical right shift fills with zeros and the arithmetic right shift fills with the lane's sign bit.
- R9: Compare-equal (12), signed less-than (13) and signed less-or-equal (14) write `cc[i]` for lane i. In halfword format `cc[7:4]` is unchanged. Compares leave `result` unchanged, and no other opcode alters `cc`.
- R10: Pick-false (15) gives the first operand's lane where `cc[i]=0` and the second operand's lane otherwise. Pick-true (16) does the reverse.
- R11: `out_valid` pulses exactly one cycle after each `in_valid`. Reset clears `result`, `cc`, `out_valid` and `illegal`. Opcodes 17 to 31 leave `result` and `cc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 5 | Operation code |
| sel | input | 5 | Format and second-operand select |
| spec | input | 5 | Register specifier, used as the immediate |
| vs | input | 64 | First operand vector |
| vt | input | 64 | Second register value |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Registered packed result |
| cc | output | 8 | Held per-lane condition bits |
| illegal | output | 1 | Illegal format flag, valid with `out_valid` |

## Verification
The assertions cover the control behaviour on every cycle:
- the strobe timing;
- the illegal-format flag and the freeze of held state that comes with it;
- the rule that only compares may change `cc`;
- the untouched upper condition bits in halfword format;
- the result being held across compares and idle cycles.

The lane arithmetic can only be shown by the bench's scenarios, which compare against a behavioural model. These scenarios cover saturation at both ends, the broadcast index, immediate zero-extension, shift-count masking, and picks that consume flags written by earlier compares.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 5'd0,
      OP_SUB   = 5'd1,
      OP_MUL   = 5'd2,
      OP_MIN   = 5'd3,
      OP_MAX   = 5'd4,
      OP_AND   = 5'd5,
      OP_OR    = 5'd6,
      OP_NOR   = 5'd7,
      OP_XOR   = 5'd8,
      OP_SLL   = 5'd9,
      OP_SRL   = 5'd10,
      OP_SRA   = 5'd11,
      OP_CEQ   = 5'd12,
      OP_CLT   = 5'd13,
      OP_CLE   = 5'd14,
      OP_PICKF = 5'd15,
      OP_PICKT = 5'd16
   } lane_op_e;

   typedef enum logic [1:0] {
      FMT_BYTE = 2'd0,
      FMT_HALF = 2'd1,
      FMT_BAD  = 2'd2
   } lane_fmt_e;

   function automatic lane_fmt_e decode_fmt(input logic [1:0] low);
      if (!low[0])     return FMT_BYTE;
      else if (!low[1]) return FMT_HALF;
      else             return FMT_BAD;
   endfunction
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
   import simd_lane_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  lane_op_e     op_i,
   input  logic         cc_i,
   output logic [W-1:0] res_o,
   output logic         flag_o
);
   localparam int SH_W = $clog2(W);
   localparam int P_W  = 2 * W;
   localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

   logic signed [W:0]     sum_s;
   logic signed [P_W-1:0] prod_s;
   logic [W:0]            prod_hi;
   logic signed [W-1:0]   a_s;
   logic [W-1:0]          sum_sat, prod_sat;
   logic [SH_W-1:0]       cnt;
   logic                  lt, eq;

   assign a_s     = a_i;
   assign sum_s   = $signed({a_i[W-1], a_i}) + $signed({b_i[W-1], b_i});
   assign prod_s  = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
   assign prod_hi = prod_s[P_W-1:W-1];
   assign sum_sat = (sum_s[W] != sum_s[W-1]) ? (sum_s[W] ? S_MIN : S_MAX) : sum_s[W-1:0];
   assign prod_sat = ((&prod_hi) || !(|prod_hi)) ? prod_s[W-1:0]
                                                 : (prod_s[P_W-1] ? S_MIN : S_MAX);
   assign cnt = b_i[SH_W-1:0];
   assign lt  = $signed(a_i) < $signed(b_i);
   assign eq  = a_i == b_i;

   always_comb begin
      res_o  = a_i;
      flag_o = 1'b0;
      case (op_i)
         OP_ADD:   res_o = sum_sat;
         OP_SUB:   res_o = a_i - b_i;
         OP_MUL:   res_o = prod_sat;
         OP_MIN:   res_o = lt ? a_i : b_i;
         OP_MAX:   res_o = lt ? b_i : a_i;
         OP_AND:   res_o = a_i & b_i;
         OP_OR:    res_o = a_i | b_i;
         OP_NOR:   res_o = ~(a_i | b_i);
         OP_XOR:   res_o = a_i ^ b_i;
         OP_SLL:   res_o = a_i << cnt;
         OP_SRL:   res_o = a_i >> cnt;
         OP_SRA:   res_o = a_s >>> cnt;
         OP_CEQ:   flag_o = eq;
         OP_CLT:   flag_o = lt;
         OP_CLE:   flag_o = lt | eq;
         OP_PICKF: res_o = cc_i ? b_i : a_i;
         OP_PICKT: res_o = cc_i ? a_i : b_i;
         default:  res_o = a_i;
      endcase
   end
endmodule

// File: rtl/simd_opnd_sel.sv
module simd_opnd_sel #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   parameter int IMM_W  = 5,
   parameter int LANES  = DATA_W / LANE_W,
   parameter int IDX_W  = $clog2(LANES)
) (
   input  logic [1:0]        mode_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [IMM_W-1:0]  spec_i,
   input  logic [DATA_W-1:0] vt_i,
   output logic [DATA_W-1:0] opnd_o
);
   logic [LANE_W-1:0] vt_lane [LANES];
   logic [LANE_W-1:0] bcast;
   logic [LANE_W-1:0] imm_ext;

   if (LANE_W < IMM_W) begin : g_imm_chk
      $error("lane width must hold the immediate");
   end

   assign bcast   = vt_lane[idx_i];
   assign imm_ext = {{(LANE_W-IMM_W){1'b0}}, spec_i};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign vt_lane[i] = vt_i[i*LANE_W +: LANE_W];
      always_comb begin
         case (mode_i)
            2'b10:   opnd_o[i*LANE_W +: LANE_W] = vt_lane[i];
            2'b11:   opnd_o[i*LANE_W +: LANE_W] = imm_ext;
            default: opnd_o[i*LANE_W +: LANE_W] = bcast;
         endcase
      end
   end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
   import simd_lane_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   parameter int IMM_W  = 5,
   parameter int CC_W   = 8,
   parameter int LANES  = DATA_W / LANE_W,
   parameter int IDX_W  = $clog2(LANES)
) (
   input  logic [1:0]        mode_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [IMM_W-1:0]  spec_i,
   input  logic [DATA_W-1:0] vs_i,
   input  logic [DATA_W-1:0] vt_i,
   input  lane_op_e          op_i,
   input  logic [CC_W-1:0]   cc_i,
   output logic [DATA_W-1:0] res_o,
   output logic [LANES-1:0]  flag_o
);
   logic [DATA_W-1:0] opnd;

   if (LANES > CC_W) begin : g_cc_chk
      $error("more lanes than condition bits");
   end

   simd_opnd_sel #(
      .DATA_W(DATA_W), .LANE_W(LANE_W), .IMM_W(IMM_W), .LANES(LANES), .IDX_W(IDX_W)
   ) u_sel (
      .mode_i(mode_i), .idx_i(idx_i), .spec_i(spec_i), .vt_i(vt_i), .opnd_o(opnd)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_unit
      simd_lane_unit #(.W(LANE_W)) u_unit (
         .a_i   (vs_i[i*LANE_W +: LANE_W]),
         .b_i   (opnd[i*LANE_W +: LANE_W]),
         .op_i  (op_i),
         .cc_i  (cc_i[i]),
         .res_o (res_o[i*LANE_W +: LANE_W]),
         .flag_o(flag_o[i])
      );
   end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
   import simd_lane_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int BYTE_W = 8,
   parameter int HALF_W = 16,
   parameter int SEL_W  = 5,
   parameter int CC_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   opcode,
   input  logic [SEL_W-1:0]  sel,
   input  logic [SEL_W-1:0]  spec,
   input  logic [DATA_W-1:0] vs,
   input  logic [DATA_W-1:0] vt,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic [CC_W-1:0]   cc,
   output logic              illegal
);
   localparam int BYTE_LANES = DATA_W / BYTE_W;
   localparam int HALF_LANES = DATA_W / HALF_W;
   localparam int BIDX_W     = $clog2(BYTE_LANES);
   localparam int HIDX_W     = $clog2(HALF_LANES);

   if (SEL_W != 5) begin : g_sel_chk
      $error("select field must be 5 bits");
   end
   if (BYTE_LANES != CC_W) begin : g_ccw_chk
      $error("condition width must equal the byte lane count");
   end
   if (HALF_W != 2 * BYTE_W) begin : g_half_chk
      $error("halfword must be two bytes");
   end

   lane_op_e             op;
   lane_fmt_e            fmt;
   logic [DATA_W-1:0]    res_b, res_h, res_q;
   logic [BYTE_LANES-1:0] flag_b;
   logic [HALF_LANES-1:0] flag_h;
   logic [CC_W-1:0]      cc_q, cc_nxt;
   logic                 vld_q, ill_q, wr_res, wr_cc;

   assign op  = lane_op_e'(opcode);
   assign fmt = decode_fmt(sel[1:0]);

   simd_lane_bank #(
      .DATA_W(DATA_W), .LANE_W(BYTE_W), .IMM_W(SEL_W), .CC_W(CC_W)
   ) u_bank_b (
      .mode_i(sel[4:3]), .idx_i(sel[3 -: BIDX_W]), .spec_i(spec),
      .vs_i(vs), .vt_i(vt), .op_i(op), .cc_i(cc_q),
      .res_o(res_b), .flag_o(flag_b)
   );

   simd_lane_bank #(
      .DATA_W(DATA_W), .LANE_W(HALF_W), .IMM_W(SEL_W), .CC_W(CC_W)
   ) u_bank_h (
      .mode_i(sel[4:3]), .idx_i(sel[3 -: HIDX_W]), .spec_i(spec),
      .vs_i(vs), .vt_i(vt), .op_i(op), .cc_i(cc_q),
      .res_o(res_h), .flag_o(flag_h)
   );

   always_comb begin
      wr_res = 1'b0;
      wr_cc  = 1'b0;
      case (op)
         OP_CEQ, OP_CLT, OP_CLE: wr_cc = 1'b1;
         OP_ADD, OP_SUB, OP_MUL, OP_MIN, OP_MAX, OP_AND, OP_OR, OP_NOR,
         OP_XOR, OP_SLL, OP_SRL, OP_SRA, OP_PICKF, OP_PICKT: wr_res = 1'b1;
         default: ;
      endcase
   end

   always_comb begin
      cc_nxt = cc_q;
      if (fmt == FMT_HALF) cc_nxt[HALF_LANES-1:0] = flag_h;
      else                 cc_nxt = flag_b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         cc_q  <= '0;
         vld_q <= 1'b0;
         ill_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         ill_q <= in_valid && (fmt == FMT_BAD);
         if (in_valid && fmt != FMT_BAD) begin
            if (wr_res) res_q <= (fmt == FMT_HALF) ? res_h : res_b;
            if (wr_cc)  cc_q  <= cc_nxt;
         end
      end
   end

   assign out_valid = vld_q;
   assign result    = res_q;
   assign cc        = cc_q;
   assign illegal   = ill_q;
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
   parameter int DATA_W = 64,
   parameter int SEL_W  = 5,
   parameter int CC_W   = 8,
   parameter int HALF_N = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [4:0]        opcode,
   input logic [SEL_W-1:0]  sel,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic [CC_W-1:0]   cc,
   input logic              illegal
);
   logic is_cmp;
   assign is_cmp = (opcode == 5'd12) || (opcode == 5'd13) || (opcode == 5'd14);

   p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !illegal && $stable(result) && $stable(cc));
   p_bad_fmt_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && sel[1:0] == 2'b11 |=> illegal && $stable(result) && $stable(cc));
   p_good_fmt_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && sel[1:0] != 2'b11 |=> !illegal);
   p_half_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && sel[1:0] == 2'b01 |=> $stable(cc[CC_W-1:HALF_N]));
   p_cc_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !is_cmp |=> $stable(cc));
   p_cmp_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && is_cmp |=> $stable(result));
endmodule

bind simd_lane_alu simd_lane_alu_chk #(
   .DATA_W(DATA_W), .SEL_W(SEL_W), .CC_W(CC_W), .HALF_N(DATA_W / HALF_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .sel(sel),
   .out_valid(out_valid), .result(result), .cc(cc), .illegal(illegal)
);

// File: tb/simd_lane_alu_bench.sv
`timescale 1ns/1ps
module simd_lane_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  opcode = '0, sel = '0, spec = '0;
   logic [63:0] vs = '0, vt = '0;
   logic        out_valid, illegal;
   logic [63:0] result;
   logic [7:0]  cc;

   int total = 0, bad = 0;
   bit done = 0;

   logic [63:0] q_res [$];
   logic [7:0]  q_cc  [$];
   logic        q_ill [$];
   string       q_tag [$];

   logic [63:0] m_res = '0;
   logic [7:0]  m_cc  = '0;

   always #2 clk = ~clk;

   simd_lane_alu u_simd_lane_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .sel(sel),
      .spec(spec), .vs(vs), .vt(vt), .out_valid(out_valid), .result(result),
      .cc(cc), .illegal(illegal)
   );

   function automatic longint sx(longint v, int w);
      longint m = (longint'(1) << w) - 1;
      v = v & m;
      if ((v >> (w - 1)) & 1) v = v - (longint'(1) << w);
      return v;
   endfunction

   function automatic longint clampv(longint v, int w);
      longint hi = (longint'(1) << (w - 1)) - 1;
      longint lo = -(longint'(1) << (w - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   task automatic apply(input logic [4:0] op, input logic [4:0] s, input logic [4:0] sp,
                        input logic [63:0] a, input logic [63:0] b, input string tag);
      int w, n, idx;
      longint m, av, bv, ua, ub, r;
      logic [63:0] nres;
      logic [7:0]  ncc;
      logic        ill;
      ill  = (s[1:0] == 2'b11);
      nres = m_res;
      ncc  = m_cc;
      if (!ill) begin
         w   = s[0] ? 16 : 8;
         n   = 64 / w;
         m   = (longint'(1) << w) - 1;
         idx = s[0] ? int'(s[3:2]) : int'(s[3:1]);
         for (int i = 0; i < n; i++) begin
            ua = longint'((a >> (i * w))) & m;
            if (s[4] == 1'b0)      ub = longint'((b >> (idx * w))) & m;
            else if (s[3] == 1'b0) ub = longint'((b >> (i * w))) & m;
            else                   ub = longint'(sp);
            av = sx(ua, w);
            bv = sx(ub, w);
            r  = ua;
            case (op)
               5'd0:  r = clampv(av + bv, w);
               5'd1:  r = av - bv;
               5'd2:  r = clampv(av * bv, w);
               5'd3:  r = (av < bv) ? av : bv;
               5'd4:  r = (av < bv) ? bv : av;
               5'd5:  r = ua & ub;
               5'd6:  r = ua | ub;
               5'd7:  r = ~(ua | ub);
               5'd8:  r = ua ^ ub;
               5'd9:  r = ua << (ub & (w - 1));
               5'd10: r = ua >> (ub & (w - 1));
               5'd11: r = av >>> (ub & (w - 1));
               5'd12: ncc[i] = (av == bv);
               5'd13: ncc[i] = (av < bv);
               5'd14: ncc[i] = (av <= bv);
               5'd15: r = m_cc[i] ? ub : ua;
               5'd16: r = m_cc[i] ? ua : ub;
               default: ;
            endcase
            if ((op <= 5'd11) || op == 5'd15 || op == 5'd16)
               nres[i*w +: 16] = (w == 16) ? 16'(r & m) : {nres[i*w+8 +: 8], 8'(r & m)};
         end
      end
      m_res = nres;
      m_cc  = ncc;
      q_res.push_back(nres);
      q_cc.push_back(ncc);
      q_ill.push_back(ill);
      q_tag.push_back(tag);
      @(negedge clk);
      in_valid = 1'b1;
      opcode = op; sel = s; spec = sp; vs = a; vt = b;
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         total++;
         if (q_res.size() == 0) begin
            bad++;
            $display("FAIL R11 unexpected strobe: actual=out_valid expected=idle");
         end else begin
            logic [63:0] er;
            logic [7:0]  ec;
            logic        ei;
            string       t;
            er = q_res.pop_front(); ec = q_cc.pop_front();
            ei = q_ill.pop_front(); t = q_tag.pop_front();
            if (result !== er || cc !== ec || illegal !== ei) begin
               bad++;
               $display("FAIL %s: actual res=%h cc=%h ill=%b expected res=%h cc=%h ill=%b",
                        t, result, cc, illegal, er, ec, ei);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R11 watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (result !== '0 || cc !== '0 || out_valid !== 1'b0 || illegal !== 1'b0) begin
         bad++;
         $display("FAIL R11 reset: actual res=%h cc=%h v=%b ill=%b expected all zero",
                  result, cc, out_valid, illegal);
      end
      rst_n = 1'b1;
      @(negedge clk);

      apply(5'd0,  5'b10110, 5'd0,  64'h7080_017F_80FF_1020, 64'h2080_7F01_FF01_1010, "R4 byte add sat");
      apply(5'd0,  5'b10101, 5'd0,  64'h7FF0_8000_1234_0001, 64'h0100_FFFF_1111_7FFF, "R4 half add sat");
      apply(5'd2,  5'b00100, 5'd0,  64'h0102_1040_F9C0_7F80, 64'h0000_0000_00F0_0000, "R2 R4 byte mul bcast idx2");
      apply(5'd2,  5'b01001, 5'd0,  64'h0002_0100_FFFF_8000, 64'h0000_0300_0000_0000, "R2 R4 half mul bcast idx2");
      apply(5'd1,  5'b11110, 5'd17, 64'h0010_8090_FF11_2233, 64'hFFFF_FFFF_FFFF_FFFF, "R3 R5 byte sub imm");
      apply(5'd1,  5'b11101, 5'd31, 64'h0000_8000_001F_7FFF, 64'h1234_5678_9ABC_DEF0, "R3 R5 half sub imm");
      apply(5'd5,  5'b10110, 5'd0,  64'hF0F0_AAAA_1234_FFFF, 64'h0FF0_5555_FF00_00FF, "R6 and");
      apply(5'd6,  5'b10110, 5'd0,  64'hF0F0_AAAA_1234_FFFF, 64'h0FF0_5555_FF00_00FF, "R6 or");
      apply(5'd7,  5'b10110, 5'd0,  64'hF0F0_AAAA_1234_0000, 64'h0FF0_5555_FF00_00FF, "R6 nor");
      apply(5'd8,  5'b10101, 5'd0,  64'hF0F0_AAAA_1234_FFFF, 64'h0FF0_5555_FF00_00FF, "R6 xor");
      apply(5'd3,  5'b10110, 5'd0,  64'h807F_0102_FE03_7F80, 64'h7F80_0201_03FE_807F, "R7 byte min");
      apply(5'd4,  5'b10101, 5'd0,  64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_FFFF_0001, "R7 half max");
      apply(5'd9,  5'b11110, 5'd9,  64'h8142_0102_FF7F_0180, 64'h0, "R8 byte sll masked count");
      apply(5'd10, 5'b10101, 5'd0,  64'h8000_F0F0_FFFF_1234, 64'h0001_0014_000F_0004, "R8 half srl");
      apply(5'd11, 5'b10110, 5'd0,  64'h8080_807F_7FF0_0F81, 64'h0108_0F03_0A01_0002, "R8 byte sra");
      apply(5'd13, 5'b10110, 5'd0,  64'h8000_7F01_FF02_0305, 64'h7F00_8002_0001_0504, "R9 byte lt");
      apply(5'd15, 5'b10110, 5'd0,  64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, "R10 byte pickf");
      apply(5'd16, 5'b10110, 5'd0,  64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, "R10 byte pickt");
      apply(5'd12, 5'b10101, 5'd0,  64'h1234_8000_0005_FFFF, 64'h1234_7FFF_0005_0000, "R9 half eq keeps upper");
      apply(5'd16, 5'b10101, 5'd0,  64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, "R10 half pickt");
      apply(5'd14, 5'b00000, 5'd0,  64'h0005_0004_0006_FF05, 64'h0000_0000_0000_0005, "R2 R9 byte le bcast idx0");
      apply(5'd0,  5'b10011, 5'd0,  64'h7F7F_7F7F_7F7F_7F7F, 64'h7F7F_7F7F_7F7F_7F7F, "R1 illegal word fmt");
      apply(5'd14, 5'b00111, 5'd0,  64'h0, 64'h1, "R1 illegal long fmt");
      apply(5'd20, 5'b10110, 5'd0,  64'h1234_5678_9ABC_DEF0, 64'h1, "R11 unused opcode");
      apply(5'd0,  5'b11110, 5'd31, 64'h0102_0304_0506_0708, 64'h0, "R3 byte add imm");

      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      total++;
      if (q_res.size() != 0) begin
         bad++;
         $display("FAIL R11 missing strobes: actual pending=%0d expected 0", q_res.size());
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule